// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Condition Flags

This block is the arithmetic and logic stage of a small 16-bit processor core. On each accepted request it combines a destination operand with a source operand and returns the result, a destination write strobe and four condition flags: carry, zero, negative and signed overflow. The register file stores whatever the block returns. The incoming carry is taken from the stored status word, so chained multi-precision sums and differences work across several requests.

Every request chooses narrow (byte) or full (word) width. All four flags are formed at the chosen width. In byte mode the upper half of both operands is ignored and the upper half of the result is forced to zero. Compare runs a subtraction and updates the flags, but it never asserts the destination write.

The supported operations are add, add with carry, subtract, subtract with borrow, compare, AND and XOR. All outputs are registered and are due one clock after the request.

Top module: `alu_bw_core`

## Requirements
- R1: After reset, every output is zero: `res`, `wr_en`, `flag_we` and the four flags.
- R2: Op code 0 (add) gives dst + src at the selected width, and C is the carry out of that width. For example, byte 0x75 + 0xC7 gives 0x3C with C=1.
- R3: Op code 1 (add with carry) gives dst + src + `carry_in`.
- R4: Op code 2 (subtract) gives dst + ~src + 1. C=1 means no borrow occurred.
- R5: Op code 3 (subtract with borrow) gives dst + ~src + `carry_in`.
- R6: Op code 4 (compare) sets the flags exactly as subtract would, and `res` shows the difference. `wr_en` stays low and `flag_we` goes high.
- R7: Op codes 5 (AND) and 6 (XOR) give the bitwise result with V=0 and C equal to the inverse of Z.
- R8: Z=1 exactly when the result at the selected width is zero.
- R9: N equals the top bit of the result at the selected width: bit 7 in byte mode, bit 15 in word mode.
- R10: For arithmetic operations, V=1 when two addends of equal sign give a sum of the other sign. For subtraction the addends are dst and ~src. V can be set when C is clear.
- R11: When `byte_mode`=1, bits 15:8 of both operands have no effect, and bits 15:8 of `res` are zero.
- R12: Op code 7 is reserved. It leaves `wr_en` and `flag_we` low, and `res` and the flags keep their previous values.
- R13: Outputs are due on the clock after the request is accepted with `in_valid`=1. Without a request, `wr_en` and `flag_we` are low on the next clock, and `res` and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A request is present this cycle |
| op | input | 3 | Operation code (0 add … 6 xor, 7 reserved) |
| byte_mode | input | 1 | 1 = byte width, 0 = word width |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| carry_in | input | 1 | Carry taken from the stored status word |
| res | output | 16 | Registered result |
| wr_en | output | 1 | Destination write strobe |
| flag_we | output | 1 | Flag write strobe |
| flag_c | output | 1 | Carry / no-borrow |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |
| flag_v | output | 1 | Signed overflow |

## Verification
Every output lags its request by exactly one rising edge. The bench therefore drives a request on a falling edge, lets one rising edge pass, and compares all seven outputs on the following falling edge against a behavioural model that it advanced at drive time. Idle and reserved cycles are compared on the same schedule. This shows that the strobes drop on those cycles while the result and the flags hold.

// File: rtl/alu_bw_pkg.sv
package alu_bw_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_ADDC = 3'd1,
      OP_SUB  = 3'd2,
      OP_SUBC = 3'd3,
      OP_CMP  = 3'd4,
      OP_AND  = 3'd5,
      OP_XOR  = 3'd6,
      OP_RSVD = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic c;
      logic z;
      logic n;
      logic v;
   } alu_flags_t;

   localparam alu_flags_t FLAGS_CLEAR = '{c: 1'b0, z: 1'b0, n: 1'b0, v: 1'b0};

endpackage

// File: rtl/alu_bw_opnd.sv
// Operand conditioning: picks the second addend, the effective carry and the
// write intents for each operation code.
module alu_bw_opnd
   import alu_bw_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] src,
   input  logic              carry_in,
   output logic [DATA_W-1:0] b_opnd,
   output logic              cin_eff,
   output logic              is_logic,
   output logic              logic_xor,
   output logic              res_wr,
   output logic              flag_wr
);

   always_comb begin
      b_opnd    = src;
      cin_eff   = 1'b0;
      is_logic  = 1'b0;
      logic_xor = 1'b0;
      res_wr    = 1'b1;
      flag_wr   = 1'b1;
      unique case (op)
         OP_ADD:  cin_eff = 1'b0;
         OP_ADDC: cin_eff = carry_in;
         OP_SUB: begin
            b_opnd  = ~src;
            cin_eff = 1'b1;
         end
         OP_SUBC: begin
            b_opnd  = ~src;
            cin_eff = carry_in;
         end
         OP_CMP: begin
            b_opnd  = ~src;
            cin_eff = 1'b1;
            res_wr  = 1'b0;
         end
         OP_AND:  is_logic = 1'b1;
         OP_XOR: begin
            is_logic  = 1'b1;
            logic_xor = 1'b1;
         end
         default: begin
            res_wr  = 1'b0;
            flag_wr = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/alu_bw_lane_add.sv
// Lane-segmented adder: one carry and one overflow tap per narrow lane.
module alu_bw_lane_add #(
   parameter int DATA_W    = 16,
   parameter int LANE_W    = 8,
   parameter bit LANE_CSEL = 1'b1,
   localparam int LANES    = DATA_W / LANE_W
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic [LANES-1:0]  lane_co,
   output logic [LANES-1:0]  lane_ov
);

   logic [LANES:0] chain;
   assign chain[0] = cin;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] a_l;
      logic [LANE_W-1:0] b_l;
      logic [LANE_W-1:0] s_l;
      logic              co_l;

      assign a_l = a[g*LANE_W +: LANE_W];
      assign b_l = b[g*LANE_W +: LANE_W];

      if (LANE_CSEL && (g > 0)) begin : g_csel
         logic [LANE_W:0] t0;
         logic [LANE_W:0] t1;
         assign t0 = {1'b0, a_l} + {1'b0, b_l};
         assign t1 = {1'b0, a_l} + {1'b0, b_l} + {{LANE_W{1'b0}}, 1'b1};
         assign {co_l, s_l} = chain[g] ? t1 : t0;
      end else begin : g_ripple
         logic [LANE_W:0] t;
         assign t = {1'b0, a_l} + {1'b0, b_l} + {{LANE_W{1'b0}}, chain[g]};
         assign {co_l, s_l} = t;
      end

      assign sum[g*LANE_W +: LANE_W] = s_l;
      assign chain[g+1]              = co_l;
      assign lane_co[g]              = co_l;
      assign lane_ov[g] = (a_l[LANE_W-1] == b_l[LANE_W-1]) &&
                          (s_l[LANE_W-1] != a_l[LANE_W-1]);
   end

endmodule

// File: rtl/alu_bw_result.sv
// Result selection, width masking and flag formation at the chosen width.
module alu_bw_result
   import alu_bw_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8,
   localparam int LANES = DATA_W / LANE_W
) (
   input  logic              byte_mode,
   input  logic              is_logic,
   input  logic              logic_xor,
   input  logic [DATA_W-1:0] dst,
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] sum,
   input  logic [LANES-1:0]  lane_co,
   input  logic [LANES-1:0]  lane_ov,
   output logic [DATA_W-1:0] res,
   output alu_flags_t        flags
);

   localparam logic [DATA_W-1:0] NARROW_MASK =
      {{(DATA_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};

   logic [DATA_W-1:0] raw;
   logic              zf;

   always_comb begin
      if (is_logic) raw = logic_xor ? (dst ^ src) : (dst & src);
      else          raw = sum;
   end

   assign res = byte_mode ? (raw & NARROW_MASK) : raw;
   assign zf  = (res == '0);

   always_comb begin
      flags   = FLAGS_CLEAR;
      flags.z = zf;
      flags.n = byte_mode ? res[LANE_W-1] : res[DATA_W-1];
      if (is_logic) begin
         flags.c = ~zf;
         flags.v = 1'b0;
      end else begin
         flags.c = byte_mode ? lane_co[0] : lane_co[LANES-1];
         flags.v = byte_mode ? lane_ov[0] : lane_ov[LANES-1];
      end
   end

endmodule

// File: rtl/alu_bw_core.sv
module alu_bw_core
   import alu_bw_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int LANE_W    = 8,
   parameter bit LANE_CSEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        op,
   input  logic              byte_mode,
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] dst,
   input  logic              carry_in,
   output logic [DATA_W-1:0] res,
   output logic              wr_en,
   output logic              flag_we,
   output logic              flag_c,
   output logic              flag_z,
   output logic              flag_n,
   output logic              flag_v
);

   localparam int LANES = DATA_W / LANE_W;

   initial begin : p_param_chk
      assert (LANE_W >= 2) else $fatal(1, "lane width too small");
      assert (DATA_W % LANE_W == 0) else $fatal(1, "data width not a lane multiple");
      assert (LANES >= 2) else $fatal(1, "at least two lanes required");
   end

   alu_op_e           op_e;
   logic [DATA_W-1:0] src_w;
   logic [DATA_W-1:0] dst_w;
   logic [DATA_W-1:0] b_opnd;
   logic              cin_eff;
   logic              is_logic;
   logic              logic_xor;
   logic              res_wr;
   logic              flag_wr;
   logic [DATA_W-1:0] sum;
   logic [LANES-1:0]  lane_co;
   logic [LANES-1:0]  lane_ov;
   logic [DATA_W-1:0] res_d;
   alu_flags_t        flags_d;
   alu_flags_t        flags_q;

   assign op_e  = alu_op_e'(op);
   assign src_w = src;
   assign dst_w = dst;

   alu_bw_opnd #(.DATA_W(DATA_W)) u_opnd (
      .op        (op_e),
      .src       (src_w),
      .carry_in  (carry_in),
      .b_opnd    (b_opnd),
      .cin_eff   (cin_eff),
      .is_logic  (is_logic),
      .logic_xor (logic_xor),
      .res_wr    (res_wr),
      .flag_wr   (flag_wr)
   );

   alu_bw_lane_add #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LANE_CSEL(LANE_CSEL)) u_add (
      .a       (dst_w),
      .b       (b_opnd),
      .cin     (cin_eff),
      .sum     (sum),
      .lane_co (lane_co),
      .lane_ov (lane_ov)
   );

   alu_bw_result #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_res (
      .byte_mode (byte_mode),
      .is_logic  (is_logic),
      .logic_xor (logic_xor),
      .dst       (dst_w),
      .src       (src_w),
      .sum       (sum),
      .lane_co   (lane_co),
      .lane_ov   (lane_ov),
      .res       (res_d),
      .flags     (flags_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res     <= '0;
         flags_q <= FLAGS_CLEAR;
         wr_en   <= 1'b0;
         flag_we <= 1'b0;
      end else begin
         wr_en   <= in_valid && res_wr;
         flag_we <= in_valid && flag_wr;
         if (in_valid && flag_wr) begin
            res     <= res_d;
            flags_q <= flags_d;
         end
      end
   end

   assign flag_c = flags_q.c;
   assign flag_z = flags_q.z;
   assign flag_n = flags_q.n;
   assign flag_v = flags_q.v;

endmodule

// File: rtl/alu_bw_chk.sv
module alu_bw_chk #(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [2:0]        op,
   input logic              byte_mode,
   input logic [DATA_W-1:0] res,
   input logic              wr_en,
   input logic              flag_we,
   input logic              flag_c,
   input logic              flag_z,
   input logic              flag_v
);

   logic       armed;
   logic       vld_q;
   logic [2:0] op_q;
   logic       byte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         vld_q  <= 1'b0;
         op_q   <= 3'd0;
         byte_q <= 1'b0;
      end else begin
         armed  <= 1'b1;
         vld_q  <= in_valid;
         op_q   <= op;
         byte_q <= byte_mode;
      end
   end

   AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && vld_q && op_q == 3'd4) |-> (!wr_en && flag_we)); // R6

   AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && flag_we && (op_q == 3'd5 || op_q == 3'd6)) |-> (!flag_v && (flag_c != flag_z))); // R7

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> (flag_z == (res == '0))); // R8

   AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && flag_we && byte_q) |-> (res[DATA_W-1:LANE_W] == '0)); // R11

   AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && vld_q && op_q == 3'd7) |-> (!wr_en && !flag_we && $stable(res))); // R12

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !vld_q) |-> (!wr_en && !flag_we)); // R13

endmodule

bind alu_bw_core alu_bw_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op        (op),
   .byte_mode (byte_mode),
   .res       (res),
   .wr_en     (wr_en),
   .flag_we   (flag_we),
   .flag_c    (flag_c),
   .flag_z    (flag_z),
   .flag_v    (flag_v)
);

// File: tb/alu_bw_core_bench.sv
`timescale 1ns/1ps
module alu_bw_core_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op = 3'd0;
   logic        byte_mode = 1'b0;
   logic [15:0] src = 16'h0;
   logic [15:0] dst = 16'h0;
   logic        carry_in = 1'b0;
   logic [15:0] res;
   logic        wr_en, flag_we, flag_c, flag_z, flag_n, flag_v;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // behavioural model state
   logic [15:0] e_res = 16'h0;
   logic        e_wr = 0, e_fwe = 0, e_c = 0, e_z = 0, e_n = 0, e_v = 0;

   always #10 clk = ~clk;

   alu_bw_core u_alu_bw_core (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .byte_mode(byte_mode), .src(src), .dst(dst), .carry_in(carry_in),
      .res(res), .wr_en(wr_en), .flag_we(flag_we),
      .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      check(tag, "res", res, e_res);
      check(tag, "wr_en", wr_en, e_wr);
      check(tag, "flag_we", flag_we, e_fwe);
      check(tag, "C", flag_c, e_c);
      check(tag, "Z", flag_z, e_z);
      check(tag, "N", flag_n, e_n);
      check(tag, "V", flag_v, e_v);
   endtask

   // advance the model for one accepted request
   task automatic model(input bit vld, input int o, input bit bm, input int s_in,
                        input int d_in, input bit ci_in);
      int w, mask, d, s, b, ci, t, r, dm, bmsb, rm;
      bit c, v;
      if (!vld || o == 7) begin
         e_wr  = 0;
         e_fwe = 0;
         return;
      end
      w = bm ? 8 : 16;
      mask = (1 << w) - 1;
      d = d_in & mask;
      s = s_in & mask;
      if (o == 5 || o == 6) begin
         r = (o == 5) ? (d & s) : (d ^ s);
         v = 0;
         c = (r != 0);
      end else begin
         case (o)
            0: begin b = s; ci = 0; end
            1: begin b = s; ci = ci_in; end
            3: begin b = (~s) & mask; ci = ci_in; end
            default: begin b = (~s) & mask; ci = 1; end
         endcase
         t = d + b + ci;
         r = t & mask;
         c = ((t >> w) & 1) != 0;
         dm = (d >> (w-1)) & 1;
         bmsb = (b >> (w-1)) & 1;
         rm = (r >> (w-1)) & 1;
         v = (dm == bmsb) && (rm != dm);
      end
      e_res = r[15:0];
      e_c = c;
      e_v = v;
      e_z = (r == 0);
      e_n = ((r >> (w-1)) & 1) != 0;
      e_wr = (o != 4);
      e_fwe = 1;
   endtask

   // drive at falling edge, compare one rising edge later at the falling edge
   task automatic step(input string tag, input bit vld, input int o, input bit bm,
                       input int s_in, input int d_in, input bit ci_in);
      in_valid  = vld;
      op        = o[2:0];
      byte_mode = bm;
      src       = s_in[15:0];
      dst       = d_in[15:0];
      carry_in  = ci_in;
      model(vld, o, bm, s_in, d_in, ci_in);
      @(negedge clk);
      check_all(tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      check_all("R1");                                   // R1 reset state
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      step("R2", 1, 0, 1, 16'h00C7, 16'h0075, 0);        // R2 0x3C C=1
      check("R2", "byte sum", res, 16'h003C);
      check("R2", "byte carry", flag_c, 1);
      step("R2", 1, 0, 0, 16'h0001, 16'h1234, 0);
      step("R3", 1, 1, 0, 16'h0000, 16'hFFFF, 1);        // R3 wraps to 0, C=1 Z=1
      check("R3", "wrap Z", flag_z, 1);
      step("R4", 1, 2, 0, 16'h0003, 16'h0005, 0);        // R4 no borrow
      check("R4", "no borrow C", flag_c, 1);
      step("R4", 1, 2, 0, 16'h0005, 16'h0003, 1);        // R4 borrow
      check("R4", "borrow C", flag_c, 0);
      step("R5", 1, 3, 0, 16'h0003, 16'h0005, 0);        // R5 5-3-1
      check("R5", "diff", res, 16'h0001);
      step("R6", 1, 4, 0, 16'h4321, 16'h4321, 0);        // R6 compare equal
      check("R6", "no write", wr_en, 0);
      step("R7", 1, 5, 1, 16'h00F0, 16'h000F, 0);        // R7 AND -> 0, C=0
      step("R7", 1, 6, 1, 16'h00F0, 16'h000F, 0);        // R7 XOR -> FF, C=1
      step("R8", 1, 0, 1, 16'h1280, 16'hAB80, 0);        // R8 R11 byte 0x80+0x80
      check("R11", "upper zero", res[15:8], 0);
      step("R9", 1, 0, 1, 16'h0001, 16'h007F, 0);        // R9 N from bit 7
      step("R10", 1, 0, 0, 16'h0001, 16'h7FFF, 0);       // R10 V without C
      check("R10", "V", flag_v, 1);
      step("R10", 1, 2, 0, 16'h0001, 16'h8000, 0);
      step("R12", 1, 7, 0, 16'h1111, 16'h2222, 1);       // R12 reserved holds
      step("R13", 0, 0, 0, 16'hFFFF, 16'hFFFF, 1);       // R13 idle holds
      step("R11", 1, 2, 1, 16'hFF01, 16'h3302, 0);       // R11 upper bits ignored

      lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a_v, b_v;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         a_v = lfsr;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         b_v = lfsr;
         step("R13", (i % 9) != 4, i % 8, lfsr[3], a_v, b_v, lfsr[7]);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule